// File: doc/BRIEF.md
# Power Mode Startup Sequencer

This block steps a lighting-driver chip through its power states: held in reset, parked in standby, bringing up the reference and oscillator, soft-starting the boost converter, and running in normal operation. It watches the active-low reset pin, the power-on reset, the standby and boost-enable control bits, and a thermal-fault flag. From these it drives the enables for the reference/oscillator core and the boost converter. It also selects pulse-frequency (soft-start) or pulse-width switching, and raises a flag while normal operation is active.

All waiting is done by counting a 1 kHz tick input. The core settle interval and the boost soft-start interval are parameters. The default of 10 ticks gives 10 ms each, and a bench can use smaller values. The boost has its own startup path. Normal mode can switch only the converter off and back on, while the rest of the chip keeps running.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst_pin_n` is low or `por` is high, all four outputs are low at once, without waiting for a clock edge, and the sequencer restarts from standby.
- R2: With reset inactive, a low `stby_n` sampled at a clock edge forces all four outputs low after that edge, from any state.
- R3: In standby with `stby_n` high, the next edge enters core startup: `ref_osc_en` high, `boost_on`, `boost_pwm` and `normal_active` low.
- R4: Core startup lasts exactly SETTLE_TICKS ticks. It ends at the edge that samples the SETTLE_TICKS-th high `tick_1k` after entry. A tick sampled on the entry edge itself does not count.
- R5: When core startup ends, the sequencer goes to boost settle if `boost_en` is high, and otherwise to normal operation with the boost off.
- R6: Boost startup holds the converter off for SETTLE_TICKS ticks. It then runs `boost_on` high with `boost_pwm` low (PFM) for SOFT_TICKS ticks. After that it enters normal operation with `boost_on` and `boost_pwm` both high.
- R7: `therm_fault` high in any non-standby state returns the sequencer to core startup on the next edge with the boost off. The interval count stays at zero while the fault lasts, so a full SETTLE_TICKS interval is needed after it clears.
- R8: In normal operation with the boost running, a low `boost_en` turns `boost_on` and `boost_pwm` off on the next edge, and `normal_active` stays high.
- R9: A low `boost_en` during boost settle or soft-start abandons the boost startup and enters normal operation with the boost off.
- R10: In normal operation with the boost off, a high `boost_en` enters boost settle on the next edge. `normal_active` is low for the whole boost startup.
- R11: `normal_active` is high only in normal operation, and never without `ref_osc_en`.
- R12: `boost_pwm` is never high while `boost_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_pin_n | input | 1 | Active-low external reset pin |
| por | input | 1 | Power-on reset, active high |
| stby_n | input | 1 | Control bit: 0 requests standby |
| boost_en | input | 1 | Control bit: 1 requests the boost converter |
| therm_fault | input | 1 | Thermal shutdown flag, active high |
| tick_1k | input | 1 | One-clock pulse at 1 kHz that paces all intervals |
| ref_osc_en | output | 1 | Enable for reference, bias and oscillator |
| boost_on | output | 1 | Boost converter switching enable |
| boost_pwm | output | 1 | 1 = PWM switching, 0 = PFM soft-start |
| normal_active | output | 1 | High while normal operation is active |

## Verification
The bench builds the block with SETTLE_TICKS = 3 and SOFT_TICKS = 4. Every timed exit is then only a few ticks away, so a single run covers the boost re-enable path, a thermal fault arriving while the boost runs, and a long pseudo-random stretch. The two intervals differ, so swapping the limits or counting one interval with the other's length would change the cycle at which `boost_pwm` rises. Back-to-back ticks are mixed with sparse ones. This shows the count advances only on sampled ticks and stays at zero while the thermal fault is held.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PS_STBY  = 3'd0,
    PS_CORE  = 3'd1,
    PS_BWAIT = 3'd2,
    PS_BSOFT = 3'd3,
    PS_RUN   = 3'd4
  } pwr_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // states whose exit is paced by the tick counter
  function automatic logic is_timed(input pwr_state_t s);
    return (s == PS_CORE) || (s == PS_BWAIT) || (s == PS_BSOFT);
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_any,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          hit
);

  // last tick of the interval is being sampled now
  assign hit = tick && (cnt == (limit - CW'(1)));

  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any)       cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (tick)     cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int CW           = 4,
  parameter int SETTLE_TICKS = 10,
  parameter int SOFT_TICKS   = 10
) (
  input  logic          clk,
  input  logic          rst_any,
  input  logic          stby_n,
  input  logic          boost_en,
  input  logic          therm_fault,
  input  logic          hit,
  output pwr_state_t    state,
  output logic          boost_live,
  output logic          tmr_clr,
  output logic [CW-1:0] limit,
  output logic          fault_evt
);

  pwr_state_t nxt;
  logic       live_nxt;

  assign fault_evt = stby_n && (state != PS_STBY) && therm_fault;
  assign limit     = (state == PS_BSOFT) ? CW'(SOFT_TICKS) : CW'(SETTLE_TICKS);

  always_comb begin
    nxt      = state;
    live_nxt = boost_live;
    if (!stby_n) begin
      nxt      = PS_STBY;
      live_nxt = 1'b0;
    end else if (fault_evt) begin
      nxt      = PS_CORE;
      live_nxt = 1'b0;
    end else begin
      unique case (state)
        PS_STBY: begin
          nxt      = PS_CORE;
          live_nxt = 1'b0;
        end
        PS_CORE: begin
          if (hit) nxt = boost_en ? PS_BWAIT : PS_RUN;
        end
        PS_BWAIT: begin
          if (!boost_en) nxt = PS_RUN;
          else if (hit)  nxt = PS_BSOFT;
        end
        PS_BSOFT: begin
          if (!boost_en) nxt = PS_RUN;
          else if (hit) begin
            nxt      = PS_RUN;
            live_nxt = 1'b1;
          end
        end
        PS_RUN: begin
          if (boost_live && !boost_en)      live_nxt = 1'b0;
          else if (!boost_live && boost_en) nxt      = PS_BWAIT;
        end
        default: begin
          nxt      = PS_STBY;
          live_nxt = 1'b0;
        end
      endcase
    end
  end

  assign tmr_clr = (nxt != state) || fault_evt || !is_timed(state);

  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any) begin
      state      <= PS_STBY;
      boost_live <= 1'b0;
    end else begin
      state      <= nxt;
      boost_live <= live_nxt;
    end
  end

endmodule

// File: rtl/pwrseq_outdec.sv
module pwrseq_outdec
  import pwrseq_pkg::*;
(
  input  pwr_state_t state,
  input  logic       boost_live,
  output logic       ref_osc_en,
  output logic       boost_on,
  output logic       boost_pwm,
  output logic       normal_active
);

  logic run_boost;

  assign run_boost     = (state == PS_RUN) && boost_live;
  assign ref_osc_en    = (state != PS_STBY);
  assign boost_on      = (state == PS_BSOFT) || run_boost;
  assign boost_pwm     = run_boost;
  assign normal_active = (state == PS_RUN);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int SETTLE_TICKS = 10,
  parameter int SOFT_TICKS   = 10
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic por,
  input  logic stby_n,
  input  logic boost_en,
  input  logic therm_fault,
  input  logic tick_1k,
  output logic ref_osc_en,
  output logic boost_on,
  output logic boost_pwm,
  output logic normal_active
);

  localparam int TMR_MAX = imax(SETTLE_TICKS, SOFT_TICKS);
  localparam int CW      = $clog2(TMR_MAX + 1);

  logic          rst_any;
  pwr_state_t    state;
  logic          boost_live;
  logic          tmr_clr;
  logic          tmr_hit;
  logic          fault_evt;
  logic [CW-1:0] tmr_limit;
  logic [CW-1:0] tmr_cnt;

  assign rst_any = !rst_pin_n || por;

  pwrseq_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_any(rst_any),
    .clr    (tmr_clr),
    .tick   (tick_1k),
    .limit  (tmr_limit),
    .cnt    (tmr_cnt),
    .hit    (tmr_hit)
  );

  pwrseq_fsm #(
    .CW          (CW),
    .SETTLE_TICKS(SETTLE_TICKS),
    .SOFT_TICKS  (SOFT_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst_any    (rst_any),
    .stby_n     (stby_n),
    .boost_en   (boost_en),
    .therm_fault(therm_fault),
    .hit        (tmr_hit),
    .state      (state),
    .boost_live (boost_live),
    .tmr_clr    (tmr_clr),
    .limit      (tmr_limit),
    .fault_evt  (fault_evt)
  );

  pwrseq_outdec u_dec (
    .state        (state),
    .boost_live   (boost_live),
    .ref_osc_en   (ref_osc_en),
    .boost_on     (boost_on),
    .boost_pwm    (boost_pwm),
    .normal_active(normal_active)
  );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int SETTLE_TICKS = 10,
  parameter int SOFT_TICKS   = 10,
  parameter int CW           = 4
) (
  input logic          clk,
  input logic          rst_any,
  input logic          stby_n,
  input logic          boost_en,
  input logic          therm_fault,
  input logic          ref_osc_en,
  input logic          boost_on,
  input logic          boost_pwm,
  input logic          normal_active,
  input logic [CW-1:0] tmr_cnt
);

  localparam int TMR_MAX = (SETTLE_TICKS > SOFT_TICKS) ? SETTLE_TICKS : SOFT_TICKS;

  // R2
  stby_off_chk: assert property (@(posedge clk) disable iff (rst_any)
    !stby_n |=> !ref_osc_en && !boost_on && !normal_active);

  // R3
  stby_exit_chk: assert property (@(posedge clk) disable iff (rst_any)
    (!ref_osc_en && stby_n) |=> ref_osc_en && !boost_on && !normal_active);

  // R4
  tmr_range_chk: assert property (@(posedge clk) disable iff (rst_any)
    int'(tmr_cnt) < TMR_MAX);

  // R6
  soft_pfm_chk: assert property (@(posedge clk) disable iff (rst_any)
    $rose(boost_on) |-> !boost_pwm);

  // R7
  therm_back_chk: assert property (@(posedge clk) disable iff (rst_any)
    (therm_fault && stby_n && ref_osc_en) |=> ref_osc_en && !boost_on && !normal_active);

  // R7
  therm_hold_chk: assert property (@(posedge clk) disable iff (rst_any)
    (therm_fault && stby_n && ref_osc_en) |=> tmr_cnt == '0);

  // R8
  boost_drop_chk: assert property (@(posedge clk) disable iff (rst_any)
    (normal_active && boost_on && !boost_en && stby_n && !therm_fault)
      |=> normal_active && !boost_on);

  // R10
  boost_reen_chk: assert property (@(posedge clk) disable iff (rst_any)
    (normal_active && !boost_on && boost_en && stby_n && !therm_fault)
      |=> !normal_active && ref_osc_en && !boost_on);

  // R11
  norm_ref_chk: assert property (@(posedge clk) disable iff (rst_any)
    normal_active |-> ref_osc_en);

  // R12
  pwm_on_chk: assert property (@(posedge clk) disable iff (rst_any)
    boost_pwm |-> boost_on);

endmodule

bind pwrseq_top pwrseq_chk #(
  .SETTLE_TICKS(SETTLE_TICKS),
  .SOFT_TICKS  (SOFT_TICKS),
  .CW          (CW)
) u_chk (
  .clk          (clk),
  .rst_any      (rst_any),
  .stby_n       (stby_n),
  .boost_en     (boost_en),
  .therm_fault  (therm_fault),
  .ref_osc_en   (ref_osc_en),
  .boost_on     (boost_on),
  .boost_pwm    (boost_pwm),
  .normal_active(normal_active),
  .tmr_cnt      (tmr_cnt)
);

// File: tb/pwrseq_top_bench.sv
`timescale 1ns/1ps
module pwrseq_top_bench;

  localparam int SET  = 3;
  localparam int SOFT = 4;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0, por = 1'b1, stby_n = 1'b0, boost_en = 1'b0;
  logic therm_fault = 1'b0, tick_1k = 1'b0;
  logic ref_osc_en, boost_on, boost_pwm, normal_active;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwrseq_top #(.SETTLE_TICKS(SET), .SOFT_TICKS(SOFT)) u_pwrseq_top (
    .clk(clk), .rst_pin_n(rst_pin_n), .por(por), .stby_n(stby_n),
    .boost_en(boost_en), .therm_fault(therm_fault), .tick_1k(tick_1k),
    .ref_osc_en(ref_osc_en), .boost_on(boost_on), .boost_pwm(boost_pwm),
    .normal_active(normal_active)
  );

  // reference model: 0 standby, 1 core, 2 boost settle, 3 soft-start, 4 normal
  int m_st = 0;
  int m_cnt = 0;
  bit m_live = 0;

  always @(posedge clk) begin
    if (!rst_pin_n || por || !stby_n) begin
      m_st = 0; m_cnt = 0; m_live = 0;
    end else if (m_st != 0 && therm_fault) begin
      m_st = 1; m_cnt = 0; m_live = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_cnt = 0;
    end else if (m_st == 4) begin
      if (m_live && !boost_en) m_live = 0;
      else if (!m_live && boost_en) begin m_st = 2; m_cnt = 0; end
    end else if (m_st != 1 && !boost_en) begin
      m_st = 4; m_cnt = 0;
    end else if (tick_1k) begin
      m_cnt++;
      if (m_st == 1 && m_cnt == SET) begin
        m_st = boost_en ? 2 : 4; m_cnt = 0;
      end else if (m_st == 2 && m_cnt == SET) begin
        m_st = 3; m_cnt = 0;
      end else if (m_st == 3 && m_cnt == SOFT) begin
        m_st = 4; m_cnt = 0; m_live = 1;
      end
    end
  end

  task automatic check(input string tag, input bit r, input bit on, input bit pwm, input bit nrm);
    n_vec++;
    if ({ref_osc_en, boost_on, boost_pwm, normal_active} !== {r, on, pwm, nrm}) begin
      n_bad++;
      $display("FAIL %s at %0t: actual ref/on/pwm/norm=%b%b%b%b expected=%b%b%b%b", tag, $time,
               ref_osc_en, boost_on, boost_pwm, normal_active, r, on, pwm, nrm);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      string tag;
      case (m_st)
        0: tag = "R2";
        1: tag = "R4";
        2, 3: tag = "R6";
        default: tag = "R8";
      endcase
      check(tag, m_st != 0, (m_st == 3) || (m_st == 4 && m_live), m_st == 4 && m_live, m_st == 4);
      n_vec++;
      if (boost_pwm && !boost_on) begin
        n_bad++;
        $display("FAIL R12 at %0t: actual pwm=1 on=0 expected pwm=0", $time);
      end
    end
  end

  task automatic cyc(input int n, input bit t);
    repeat (n) begin
      tick_1k = t;
      @(negedge clk); #1;
    end
    tick_1k = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk); #1;
    cyc(3, 0);
    check("R1", 0, 0, 0, 0);
    por = 0; rst_pin_n = 1;
    cyc(3, 0);
    check("R2", 0, 0, 0, 0);
    stby_n = 1; boost_en = 1;
    cyc(1, 0);
    check("R3", 1, 0, 0, 0);
    cyc(2, 1); cyc(3, 0);
    check("R4", 1, 0, 0, 0);
    cyc(1, 1);
    check("R5", 1, 0, 0, 0);
    cyc(2, 1);
    check("R6", 1, 0, 0, 0);
    cyc(1, 1);
    check("R6", 1, 1, 0, 0);
    cyc(3, 1);
    check("R6", 1, 1, 0, 0);
    cyc(1, 1);
    check("R11", 1, 1, 1, 1);
    boost_en = 0; cyc(1, 0);
    check("R8", 1, 0, 0, 1);
    boost_en = 1; cyc(1, 0);
    check("R10", 1, 0, 0, 0);
    cyc(1, 1);
    boost_en = 0; cyc(1, 0);
    check("R9", 1, 0, 0, 1);
    boost_en = 1; cyc(1, 0);
    cyc(3, 1); cyc(4, 1);
    check("R6", 1, 1, 1, 1);
    therm_fault = 1; cyc(1, 0);
    check("R7", 1, 0, 0, 0);
    cyc(5, 1);
    check("R7", 1, 0, 0, 0);
    therm_fault = 0;
    cyc(2, 1);
    check("R7", 1, 0, 0, 0);
    cyc(1, 1); cyc(3, 1);
    check("R7", 1, 1, 0, 0);
    cyc(4, 1);
    stby_n = 0; cyc(1, 0);
    check("R2", 0, 0, 0, 0);
    stby_n = 1; boost_en = 0; cyc(1, 0);
    cyc(3, 1);
    check("R5", 1, 0, 0, 1);
    por = 1; #1;
    check("R1", 0, 0, 0, 0);
    cyc(2, 0);
    por = 0;
    cyc(1, 0);
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 39) == 0) stby_n = ~stby_n;
      else if (!stby_n && $urandom_range(0, 3) == 0) stby_n = 1;
      therm_fault = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 14) == 0) boost_en = ~boost_en;
      por = ($urandom_range(0, 299) == 0);
      cyc(1, $urandom_range(0, 1) == 1);
    end
    por = 0;
    cyc(2, 0);
    finish_run();
  end

endmodule